// File: doc/BRIEF.md
# Sequential Read Prefetch Unit

This block sits on the read path between a bus target and a slower local bus. When a host read misses, the block fetches the requested word from the local side. It then reads ahead through the following 32-bit words and keeps them in a 16-entry buffer. A later host read is answered from that buffer only if its address continues the stream, meaning it is longword aligned and exactly 4 above the address served before it.

The host keeps `req_valid` and `req_addr` steady until `rsp_valid` pulses. The block ignores the request input during the cycle in which `rsp_valid` is high, which gives the host one cycle to present the next request. The local port carries one read at a time. `loc_rd_valid` pulses for one cycle with the address, and the local side answers later with a one-cycle `loc_rd_done` and the data. A host write address is also watched: any write landing inside the words that are buffered or being fetched discards the stream.

`depth_sel` sets how far the block reads ahead. Code 0 turns read-ahead off, codes 1, 2 and 3 select 4, 8 and 16 words, code 4 selects unlimited streaming, and codes 5 to 7 behave like code 0. The code is sampled when a miss issues its local read.

Top module: `rd_prefetch_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `rsp_valid`, `rsp_hit` and `loc_rd_valid` are 0, and no local read is issued until a host read arrives.
- R2: With `depth_sel` 0, 5, 6 or 7, every host read produces exactly one local read at the request address and answers with `rsp_hit`=0 and that word; no further local reads follow.
- R3: With `depth_sel` 1, 2 or 3 (4, 8 or 16 words), an aligned miss at address A is followed by exactly N more local reads, at A+4, A+8, ... A+4N, in ascending order.
- R4: A request that is longword aligned, equals the previously served address plus 4, and whose word is buffered is answered with `rsp_hit`=1 and that word. The response is visible in the cycle after the edge that accepts the request.
- R5: A request with `req_addr[1:0]` not 0 always misses. It reads that exact address once, starts no read-ahead, and the aligned request 4 above it also misses.
- R6: A request that does not continue the stream discards every buffered or in-flight word, so a later read of a previously buffered address misses and returns the correct local word.
- R7: With `depth_sel` 4, read-ahead continues until 16 words are buffered (17 local reads counting the miss), then stops, and issues one new read for each word the host consumes.
- R8: A write with `wr_valid`=1 whose address lies from the next expected address up to, but not including, the next address to be fetched discards the stream, so the next consecutive read misses. Writes outside that range change nothing, and the next read still hits.
- R9: A miss is answered with `rsp_hit`=0 and the local word in the cycle after the edge that samples `loc_rd_done`. No response comes earlier.
- R10: A consecutive request that finds the buffer empty while a read-ahead word is still due waits and is answered with `rsp_hit`=1. Once a fixed-depth burst is used up, the next consecutive request misses and starts a new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| depth_sel | input | 3 | Read-ahead depth code (0 off, 1/2/3 = 4/8/16 words, 4 unlimited) |
| req_valid | input | 1 | Host read request, held until answered |
| req_addr | input | AW | Host read byte address |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Response came from the buffer |
| rsp_data | output | DW | Response word |
| wr_valid | input | 1 | Host write observed this cycle |
| wr_addr | input | AW | Address of the observed write |
| loc_rd_valid | output | 1 | One-cycle local read command |
| loc_rd_addr | output | AW | Local read address |
| loc_rd_done | input | 1 | Local read data strobe |
| loc_rd_data | input | DW | Local read data |

## Verification
A wrong stream pointer shows up at the ports as a hit carrying the word of a neighbouring address, or as an extra or missing local read. The bench catches either on the next host read, because every response word is compared with a value computed from its address. A wrong fetch counter or fill limit changes the number of local reads issued within one settle window after a miss, so the bench counts those reads and their addresses after every sweep point. A missed invalidation or flush surfaces on the very next consecutive read, as a hit where a miss was due.

// File: rtl/rpf_pkg.sv
package rpf_pkg;

  typedef enum logic [2:0] {
    PF_OFF  = 3'd0,
    PF_W4   = 3'd1,
    PF_W8   = 3'd2,
    PF_W16  = 3'd3,
    PF_CONT = 3'd4
  } pf_mode_e;

  // Words read ahead after a miss in the fixed modes; 0 otherwise.
  function automatic int unsigned pf_words(input logic [2:0] code);
    case (code)
      PF_W4:   return 4;
      PF_W8:   return 8;
      PF_W16:  return 16;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/rpf_buf.sv
module rpf_buf #(
  parameter  int DW    = 32,
  parameter  int DEPTH = 16,
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] count
);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count_q;
  logic [DW-1:0] rd_q;

  // Storage without reset and with a registered read, so it maps to block RAM.
  // The two pointers meet only when the buffer is empty or full, so a push and
  // a pop never touch the same entry in one cycle.
  always_ff @(posedge clk) begin
    if (push) mem_q[wr_ptr] <= push_data;
    if (pop)  rd_q <= mem_q[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count_q <= count_q + CW'(push) - CW'(pop);
    end
  end

  assign rd_data = rd_q;
  assign count   = count_q;

  // R7: read-ahead never writes into a full buffer
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    push |-> (count_q < CW'(DEPTH)));

  // R4: a hit is only served from a non-empty buffer
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count_q != '0));

endmodule

// File: rtl/rpf_stream.sv
module rpf_stream #(
  parameter  int AW    = 32,
  parameter  int DEPTH = 16,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int WW    = AW - 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] start_words,
  input  logic          start_cont,
  input  logic          stop,
  input  logic          advance,
  input  logic          issue_ok,
  input  logic [CW-1:0] buf_count,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  output logic          stream_on,
  output logic [AW-1:0] exp_addr,
  output logic [AW-1:0] fetch_addr,
  output logic          fetch_go,
  output logic          more,
  output logic          wr_hit
);

  logic          on_q, cont_q;
  logic [CW-1:0] left_q;
  logic [AW-1:0] exp_q, fetch_q;

  // Fixed modes read until the count runs out; the unlimited mode reads until
  // the buffer is full (no read is in flight whenever issue_ok is high).
  assign fetch_go = on_q & issue_ok &
                    (cont_q ? (buf_count < CW'(DEPTH)) : (left_q != '0));
  assign more     = cont_q | (left_q != '0);

  // Covered window: next expected word up to the next word still to be fetched.
  // Both bounds are word aligned, so a byte compare acts on whole words.
  assign wr_hit   = on_q & wr_valid & (wr_addr >= exp_q) & (wr_addr < fetch_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q    <= 1'b0;
      cont_q  <= 1'b0;
      left_q  <= '0;
      exp_q   <= '0;
      fetch_q <= '0;
    end else if (stop) begin
      on_q    <= 1'b0;
    end else if (start) begin
      on_q    <= start_cont | (start_words != '0);
      cont_q  <= start_cont;
      left_q  <= start_words;
      exp_q   <= start_addr;
      fetch_q <= start_addr;
    end else begin
      if (fetch_go) begin
        fetch_q <= fetch_q + AW'(4);
        if (!cont_q) left_q <= left_q - 1'b1;
      end
      if (advance) exp_q <= exp_q + AW'(4);
    end
  end

  assign stream_on  = on_q;
  assign exp_addr   = exp_q;
  assign fetch_addr = fetch_q;

  // R7: words ahead of the host never exceed the buffer size
  p_window_bound_r7: assert property (@(posedge clk) disable iff (rst)
    on_q |-> ((fetch_q[AW-1:2] - exp_q[AW-1:2]) <= WW'(DEPTH)));

endmodule

// File: rtl/rd_prefetch_unit.sv
module rd_prefetch_unit
  import rpf_pkg::*;
#(
  parameter  int AW    = 32,
  parameter  int DW    = 32,
  parameter  int DEPTH = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    depth_sel,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  output logic          rsp_hit,
  output logic [DW-1:0] rsp_data,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  output logic          loc_rd_valid,
  output logic [AW-1:0] loc_rd_addr,
  input  logic          loc_rd_done,
  input  logic [DW-1:0] loc_rd_data
);

  // Local port state: one read outstanding, either demand or read-ahead.
  logic          spec_busy, dem_busy, drop_q;
  logic          loc_vld_q;
  logic [AW-1:0] loc_addr_q;
  // Read-ahead settings captured when the demand read issues.
  logic [CW-1:0] pend_words;
  logic          pend_cont, pend_al;
  // Response registers.
  logic          rsp_valid_q, rsp_hit_q;
  logic [DW-1:0] miss_q;

  logic [CW-1:0] buf_count;
  logic [DW-1:0] buf_rd;
  logic          stream_on, fetch_go, more, wr_hit;
  logic [AW-1:0] exp_addr, fetch_addr;

  logic          req_take, aligned, seq, hit_go, hold, miss, flush;
  logic          dem_go, dem_done, spec_done, push, issue_ok;
  logic [CW-1:0] sel_words;

  always_comb begin
    int unsigned w;
    w = pf_words(depth_sel);
    if (w > DEPTH) w = DEPTH;
    sel_words = CW'(w);
  end

  assign dem_done  = loc_rd_done & dem_busy;
  assign spec_done = loc_rd_done & spec_busy;

  // Request is not looked at while its answer is on the port or a miss waits.
  assign req_take = req_valid & ~rsp_valid_q & ~dem_busy;
  assign aligned  = (req_addr[1:0] == 2'b00);
  assign seq      = stream_on & aligned & (req_addr == exp_addr);
  assign hit_go   = req_take & seq & (buf_count != '0) & ~wr_hit;
  // R10: consecutive request, buffer empty, read-ahead word still due
  assign hold     = req_take & seq & (buf_count == '0) & (spec_busy | more) & ~wr_hit;
  assign miss     = req_take & ~hit_go & ~hold;
  // R6, R8: any miss or covering write drops the stream
  assign flush    = miss | wr_hit;
  assign dem_go   = miss & ~spec_busy;
  assign issue_ok = ~spec_busy & ~dem_busy & ~flush;
  assign push     = spec_done & ~drop_q & ~flush;

  rpf_buf #(
    .DW    (DW),
    .DEPTH (DEPTH)
  ) u_buf (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .push      (push),
    .push_data (loc_rd_data),
    .pop       (hit_go),
    .rd_data   (buf_rd),
    .count     (buf_count)
  );

  rpf_stream #(
    .AW    (AW),
    .DEPTH (DEPTH)
  ) u_stream (
    .clk         (clk),
    .rst         (rst),
    .start       (dem_done),
    .start_addr  (loc_addr_q + AW'(4)),
    .start_words (pend_al ? pend_words : '0),
    .start_cont  (pend_al & pend_cont),
    .stop        (flush),
    .advance     (hit_go),
    .issue_ok    (issue_ok),
    .buf_count   (buf_count),
    .wr_valid    (wr_valid),
    .wr_addr     (wr_addr),
    .stream_on   (stream_on),
    .exp_addr    (exp_addr),
    .fetch_addr  (fetch_addr),
    .fetch_go    (fetch_go),
    .more        (more),
    .wr_hit      (wr_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      loc_vld_q  <= 1'b0;
      loc_addr_q <= '0;
      spec_busy  <= 1'b0;
      dem_busy   <= 1'b0;
      drop_q     <= 1'b0;
      pend_words <= '0;
      pend_cont  <= 1'b0;
      pend_al    <= 1'b0;
    end else begin
      loc_vld_q <= dem_go | fetch_go;
      if (dem_go) begin
        loc_addr_q <= req_addr;
        pend_words <= sel_words;
        pend_cont  <= (pf_mode_e'(depth_sel) == PF_CONT);
        pend_al    <= aligned;
      end else if (fetch_go) begin
        loc_addr_q <= fetch_addr;
      end
      if (fetch_go)       spec_busy <= 1'b1;
      else if (spec_done) spec_busy <= 1'b0;
      if (dem_go)         dem_busy  <= 1'b1;
      else if (dem_done)  dem_busy  <= 1'b0;
      // An in-flight read-ahead word outlived its stream: discard on arrival.
      if (loc_rd_done)              drop_q <= 1'b0;
      else if (flush && spec_busy)  drop_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      miss_q      <= '0;
    end else begin
      rsp_valid_q <= hit_go | dem_done;
      if (hit_go)        rsp_hit_q <= 1'b1;
      else if (dem_done) rsp_hit_q <= 1'b0;
      if (dem_done)      miss_q    <= loc_rd_data;
    end
  end

  assign rsp_valid    = rsp_valid_q;
  assign rsp_hit      = rsp_hit_q;
  assign rsp_data     = rsp_hit_q ? buf_rd : miss_q;
  assign loc_rd_valid = loc_vld_q;
  assign loc_rd_addr  = loc_addr_q;

  // R1: quiet ports right after reset
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!rsp_valid && !rsp_hit && !loc_rd_valid));

  // R3: local commands are single-cycle pulses, one read outstanding
  p_single_cmd_r3: assert property (@(posedge clk) disable iff (rst)
    loc_rd_valid |=> !loc_rd_valid);

  // R5: a buffered answer only ever goes to an aligned request
  p_hit_aligned_r5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> ($past(req_addr[1:0]) == 2'b00));

  // R9: a miss answer follows a local data strobe by one cycle
  p_miss_after_data_r9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> $past(loc_rd_done));

endmodule

// File: tb/rd_prefetch_unit_tb.sv
module rd_prefetch_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW     = 32;
  localparam int DW     = 32;
  localparam int LAT    = 2;
  localparam int SETTLE = 120;
  localparam int WDOG   = 150000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    depth_sel = 3'd0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          rsp_valid, rsp_hit;
  logic [DW-1:0] rsp_data;
  logic          wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic          loc_rd_valid;
  logic [AW-1:0] loc_rd_addr;
  logic          loc_rd_done = 1'b0;
  logic [DW-1:0] loc_rd_data = '0;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  int loc_cnt = 0;
  int lat_cnt = 0;
  logic [AW-1:0] pend_a = '0;
  logic [AW-1:0] addr_log [0:1023];

  always #(CLK_PERIOD/2) clk = ~clk;

  rd_prefetch_unit #(.AW(AW), .DW(DW), .DEPTH(16)) u_dut (
    .clk          (clk),
    .rst          (rst),
    .depth_sel    (depth_sel),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_data     (rsp_data),
    .wr_valid     (wr_valid),
    .wr_addr      (wr_addr),
    .loc_rd_valid (loc_rd_valid),
    .loc_rd_addr  (loc_rd_addr),
    .loc_rd_done  (loc_rd_done),
    .loc_rd_data  (loc_rd_data)
  );

  function automatic logic [DW-1:0] model(input logic [AW-1:0] a);
    return {a[15:0] ^ 16'h5A3C, a[31:16] ^ a[15:0]};
  endfunction

  // Local side: answers each command LAT falling edges after seeing it.
  always @(negedge clk) begin
    if (rst) begin
      lat_cnt     = 0;
      loc_rd_done = 1'b0;
    end else begin
      loc_rd_done = 1'b0;
      if (lat_cnt > 0) begin
        lat_cnt = lat_cnt - 1;
        if (lat_cnt == 0) begin
          loc_rd_done = 1'b1;
          loc_rd_data = model(pend_a);
        end
      end
      if (loc_rd_valid) begin
        pend_a = loc_rd_addr;
        addr_log[loc_cnt % 1024] = loc_rd_addr;
        loc_cnt = loc_cnt + 1;
        lat_cnt = LAT;
      end
    end
  end

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > WDOG) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WDOG);
      report();
    end
  end

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors = vectors + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d,
                         output logic h, output int lat);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    lat = 0;
    d = '0;
    h = 1'b0;
    for (int k = 1; k <= 2000; k++) begin
      @(negedge clk);
      if (rsp_valid) begin
        lat = k;
        d = rsp_data;
        h = rsp_hit;
        break;
      end
    end
    req_valid = 1'b0;
    if (lat == 0) chk("R9 response timeout", 32'd0, 32'd1);
  endtask

  task automatic rd_chk(input string tag, input logic [AW-1:0] a, input logic exp_hit);
    logic [DW-1:0] d;
    logic h;
    int lat;
    do_read(a, d, h, lat);
    chk({tag, " hit"}, DW'(h), DW'(exp_hit));
    chk({tag, " data"}, d, model(a));
  endtask

  task automatic do_write(input logic [AW-1:0] a);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = a;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [AW-1:0] b;
    logic [DW-1:0] d;
    logic h;
    int lat, c0, n;
    bit ok;

    // R1: reset state
    repeat (4) @(negedge clk);
    chk("R1 rsp_valid in reset", DW'(rsp_valid), 0);
    chk("R1 loc_rd_valid in reset", DW'(loc_rd_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rsp_hit after reset", DW'(rsp_hit), 0);
    settle(8);
    chk("R1 no local read while idle", DW'(loc_cnt), 0);

    // Sweep of every depth code over two base regions (R2, R3, R4, R7, R9, R10)
    for (int bi = 0; bi < 2; bi++) begin
      for (int code = 0; code < 8; code++) begin
        b = (bi == 0 ? 32'h0000_1000 : 32'h0004_0F00) + AW'(code * 32'h1000);
        n = (code == 1) ? 4 : (code == 2) ? 8 : (code == 3 || code == 4) ? 16 : 0;
        depth_sel = 3'(code);
        settle(SETTLE);
        c0 = loc_cnt;
        do_read(b, d, h, lat);
        chk("R9 miss hit flag", DW'(h), 0);
        chk("R9 miss data", d, model(b));
        chk("R9 miss latency", DW'(lat), DW'(LAT + 2));
        settle(SETTLE);
        if (n == 0) chk("R2 local reads per miss", DW'(loc_cnt - c0), 1);
        else if (code == 4) chk("R7 fill count", DW'(loc_cnt - c0), DW'(n + 1));
        else chk("R3 burst count", DW'(loc_cnt - c0), DW'(n + 1));
        ok = 1'b1;
        for (int i = 0; i <= n; i++)
          if (addr_log[(c0 + i) % 1024] !== b + AW'(4 * i)) ok = 1'b0;
        chk("R3 burst address order", DW'(ok), 1);
        for (int i = 1; i <= n; i++) begin
          do_read(b + AW'(4 * i), d, h, lat);
          chk("R4 hit flag", DW'(h), 1);
          chk("R4 hit data", d, model(b + AW'(4 * i)));
          if (i == 1) chk("R4 hit latency", DW'(lat), 1);
        end
        if (code == 4) rd_chk("R7 read past first fill", b + AW'(4 * (n + 1)), 1'b1);
        else if (n == 0) rd_chk("R2 next word misses", b + AW'(4), 1'b0);
        else rd_chk("R10 burst used up", b + AW'(4 * (n + 1)), 1'b0);
      end
    end

    // R10: consecutive read right after a miss waits for read-ahead and hits
    depth_sel = 3'd1;
    settle(SETTLE);
    b = 32'h0010_0000;
    rd_chk("R10 demand", b, 1'b0);
    rd_chk("R10 waits for prefetch", b + 4, 1'b1);
    rd_chk("R10 following hit", b + 8, 1'b1);

    // R5: misaligned requests
    depth_sel = 3'd3;
    settle(SETTLE);
    b = 32'h0020_0000;
    c0 = loc_cnt;
    rd_chk("R5 misaligned miss", b + 2, 1'b0);
    settle(SETTLE);
    chk("R5 single local read", DW'(loc_cnt - c0), 1);
    chk("R5 exact address", addr_log[c0 % 1024], b + 2);
    c0 = loc_cnt;
    rd_chk("R5 next aligned misses", b + 6 + 2, 1'b0);
    rd_chk("R5 plus four after misaligned", b + 6, 1'b0);
    settle(SETTLE);

    // R6: non-consecutive request discards the buffer
    depth_sel = 3'd2;
    settle(SETTLE);
    b = 32'h0030_0000;
    rd_chk("R6 demand", b, 1'b0);
    settle(SETTLE);
    rd_chk("R6 hit before jump", b + 4, 1'b1);
    rd_chk("R6 jump", b + 32'h800, 1'b0);
    rd_chk("R6 old word after jump", b + 8, 1'b0);
    // jump while read-ahead still in flight
    rd_chk("R6 jump in flight", b + 32'h4000, 1'b0);
    rd_chk("R6 stale word not returned", b + 32'h4000 + 8, 1'b0);
    settle(SETTLE);

    // R7: unlimited mode refills one word per consumed word, stops on a jump
    depth_sel = 3'd4;
    settle(SETTLE);
    b = 32'h0040_0000;
    c0 = loc_cnt;
    rd_chk("R7 demand", b, 1'b0);
    settle(SETTLE);
    chk("R7 stops when full", DW'(loc_cnt - c0), 17);
    rd_chk("R7 consume one", b + 4, 1'b1);
    settle(SETTLE);
    chk("R7 one refill", DW'(loc_cnt - c0), 18);
    chk("R7 refill address", addr_log[(c0 + 17) % 1024], b + 32'd68);
    for (int i = 2; i < 24; i++) rd_chk("R7 streaming hit", b + AW'(4 * i), 1'b1);
    settle(SETTLE);
    c0 = loc_cnt;
    rd_chk("R7 jump ends stream", b + 32'h2000, 1'b0);
    settle(SETTLE);
    chk("R7 new fill only", DW'(loc_cnt - c0), 17);

    // R8: write invalidation window
    depth_sel = 3'd3;
    settle(SETTLE);
    b = 32'h0050_0000;
    rd_chk("R8 demand", b, 1'b0);
    settle(SETTLE);
    do_write(b + 32'd68);
    rd_chk("R8 write at fetch edge ignored", b + 4, 1'b1);
    do_write(b + 4);
    do_write(b + 32'h1000);
    rd_chk("R8 writes outside ignored", b + 8, 1'b1);
    do_write(b + 32'd40);
    rd_chk("R8 covered write invalidates", b + 12, 1'b0);
    settle(SETTLE);
    rd_chk("R8 new stream hits", b + 16, 1'b1);
    do_write(b + 20);
    rd_chk("R8 write at expected word", b + 20, 1'b0);

    settle(10);
    report();
  end

endmodule